// File: doc/BRIEF.md
# Motor Drive Fault, Lock and Enable Supervisor

This block sits between the protection comparators of a three-phase motor pre-driver and its commutation logic. It takes digital flags for undervoltage, overtemperature, overvoltage and low-side overcurrent. It also takes single-cycle ticks from the main chopping oscillator (top and bottom of its ramp) and from the slow lock-detect oscillator, a strobe for every hall-sensor step, and the direction, brake and enable pins. From these it produces one command that forces every gate off, a fault flag meant for an open-drain pin, and a standby indication.

An overcurrent event starts a fixed off-time that is counted on oscillator top ticks and is released on a bottom tick. A stalled rotor is caught by a counter of lock-oscillator ticks, and any sign of motion or operator action clears it. The enable pin is active low. Raising it disables the outputs only after several bottom ticks, so a short high pulse clears the lock counter without interrupting drive.

Top module: `fault_lock_supervisor`

## Requirements
- R1: An `oc_det_i` pulse seen while `outs_off_o` is low sets `outs_off_o` and `flag_lo_o` from the next cycle. They stay set while 256 (`OCP_OFF_CYCLES`) `osc_top_i` ticks are counted.
- R2: On the 256th top tick `flag_lo_o` is released, but `outs_off_o` stays high until the next `osc_bot_i` tick, after which drive resumes.
- R3: The overcurrent off-time is unaffected by the enable pin and by further `oc_det_i` pulses: its flag release falls on exactly the 256th top tick regardless.
- R4: While `uv_i`, `ot_i` or `ov_i` is high, `outs_off_o` is high. Outside standby, `flag_lo_o` is high in the same cycle. With no fault and no standby, neither flag drive is active (the pin floats).
- R5: Lock ticks are counted only in rotation (`en_n_i`=0, `brake_n_i`=1). After 256 (`LOCK_CYCLES`) counted ticks with no clear, `outs_off_o` and `flag_lo_o` go high one cycle after the last tick.
- R6: The lock count and a lock shutdown are cleared by any of these: a `hall_step_i` strobe, `brake_n_i` falling, `en_n_i` rising, or any change of `dir_i`. Protection flags do not clear it.
- R7: While `en_n_i` is high the lock count is held at zero and no lock shutdown is present.
- R8: With `en_n_i` high, outputs are disabled on the 4th (`DIS_BOTTOMS`) bottom tick. If `en_n_i` falls earlier the countdown is dropped. Once disabled, drive returns on the first bottom tick with `en_n_i` low.
- R9: Standby (`en_n_i`=1 and `brake_n_i`=0) sets `standby_o` and `flag_hi_o`, clears `flag_lo_o`, and forces `outs_off_o`.
- R10: After reset the outputs are disabled, so `outs_off_o` is high until the first bottom tick with `en_n_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_i | input | 1 | Undervoltage flag |
| ot_i | input | 1 | Overtemperature flag |
| ov_i | input | 1 | Overvoltage flag |
| oc_det_i | input | 1 | Low-side overcurrent detect |
| osc_top_i | input | 1 | Main oscillator top tick |
| osc_bot_i | input | 1 | Main oscillator bottom tick |
| lock_tick_i | input | 1 | Lock oscillator tick |
| hall_step_i | input | 1 | Strobe on each hall state change |
| dir_i | input | 1 | Rotation direction |
| brake_n_i | input | 1 | Brake request, active low |
| en_n_i | input | 1 | Enable pin, low = run, high = disable |
| outs_off_o | output | 1 | Force all gate outputs off |
| flag_lo_o | output | 1 | Pull fault pin low |
| flag_hi_o | output | 1 | Drive fault pin high (standby) |
| standby_o | output | 1 | Standby state |

## Verification
The hardest case to reach is a lock shutdown that lands on exactly the 256th counted tick while other events are mixed in: a protection flag that must not clear the count, a brake hold that must freeze it, and an enable pulse shorter than four bottom ticks that must clear it without disabling drive. Directed sequences drive precise tick counts through each of these, and then check the cycles just before and just after the boundary. A long seeded random phase follows, with sparse hall strobes and pin toggles, so that lock and overcurrent windows keep overlapping. A reference model in the bench is compared with the outputs in every cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    OCP_IDLE = 2'd0,
    OCP_OFF  = 2'd1,
    OCP_WAIT = 2'd2
  } ocp_state_e;
endpackage

// File: rtl/ocp_off_timer.sv
module ocp_off_timer #(
  parameter int OFF_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_det_i,
  input  logic top_i,
  input  logic bot_i,
  output logic off_o,
  output logic flag_o
);
  import sup_pkg::*;
  localparam int CW = (OFF_CYCLES > 2) ? $clog2(OFF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(OFF_CYCLES - 1);

  ocp_state_e state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OCP_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        OCP_IDLE: if (oc_det_i) begin
          state_q <= OCP_OFF;
          cnt_q   <= '0;
        end
        OCP_OFF: if (top_i) begin
          if (cnt_q == LAST) begin
            state_q <= OCP_WAIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        OCP_WAIT: if (bot_i) state_q <= OCP_IDLE;
        default: state_q <= OCP_IDLE;
      endcase
    end
  end

  assign off_o  = (state_q != OCP_IDLE);
  assign flag_o = (state_q == OCP_OFF);
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int LOCK_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hall_i,
  input  logic dir_i,
  input  logic en_n_i,
  input  logic brake_n_i,
  output logic locked_o
);
  localparam int CW = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic locked_q, dir_q, en_q, brake_q;
  logic clr, run;

  // any motion or operator action; enable high also holds the count
  assign clr = hall_i | (brake_q & ~brake_n_i) | (~en_q & en_n_i)
             | (dir_q ^ dir_i) | en_n_i;
  assign run = ~en_n_i & brake_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      dir_q    <= 1'b0;
      en_q     <= 1'b1;
      brake_q  <= 1'b1;
    end else begin
      dir_q   <= dir_i;
      en_q    <= en_n_i;
      brake_q <= brake_n_i;
      if (clr) begin
        cnt_q    <= '0;
        locked_q <= 1'b0;
      end else if (run && !locked_q && tick_i) begin
        if (cnt_q == LAST) begin
          locked_q <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/enable_seq.sv
module enable_seq #(
  parameter int DIS_BOTTOMS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_n_i,
  input  logic bot_i,
  output logic dis_o
);
  localparam int CW = (DIS_BOTTOMS > 2) ? $clog2(DIS_BOTTOMS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIS_BOTTOMS - 1);

  logic [CW-1:0] cnt_q;
  logic dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dis_q <= 1'b1;
    end else if (en_n_i) begin
      if (!dis_q && bot_i) begin
        if (cnt_q == LAST) begin
          dis_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else begin
      cnt_q <= '0;
      if (dis_q && bot_i) dis_q <= 1'b0;
    end
  end

  assign dis_o = dis_q;
endmodule

// File: rtl/fault_lock_supervisor.sv
module fault_lock_supervisor #(
  parameter int OCP_OFF_CYCLES = 256,
  parameter int LOCK_CYCLES    = 256,
  parameter int DIS_BOTTOMS    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  input  logic ot_i,
  input  logic ov_i,
  input  logic oc_det_i,
  input  logic osc_top_i,
  input  logic osc_bot_i,
  input  logic lock_tick_i,
  input  logic hall_step_i,
  input  logic dir_i,
  input  logic brake_n_i,
  input  logic en_n_i,
  output logic outs_off_o,
  output logic flag_lo_o,
  output logic flag_hi_o,
  output logic standby_o
);
  logic ocp_off, ocp_flag, lock_hit, drv_dis;
  logic prot, standby;

  ocp_off_timer #(.OFF_CYCLES(OCP_OFF_CYCLES)) u_ocp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oc_det_i(oc_det_i),
    .top_i   (osc_top_i),
    .bot_i   (osc_bot_i),
    .off_o   (ocp_off),
    .flag_o  (ocp_flag)
  );

  lock_monitor #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (lock_tick_i),
    .hall_i   (hall_step_i),
    .dir_i    (dir_i),
    .en_n_i   (en_n_i),
    .brake_n_i(brake_n_i),
    .locked_o (lock_hit)
  );

  enable_seq #(.DIS_BOTTOMS(DIS_BOTTOMS)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_n_i(en_n_i),
    .bot_i (osc_bot_i),
    .dis_o (drv_dis)
  );

  assign prot       = uv_i | ot_i | ov_i;
  assign standby    = en_n_i & ~brake_n_i;
  assign standby_o  = standby;
  assign outs_off_o = standby | prot | ocp_off | lock_hit | drv_dis;
  assign flag_hi_o  = standby;
  assign flag_lo_o  = ~standby & (prot | ocp_flag | lock_hit);
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic uv_i,
  input logic ot_i,
  input logic ov_i,
  input logic oc_det_i,
  input logic en_n_i,
  input logic outs_off_o,
  input logic flag_lo_o,
  input logic flag_hi_o,
  input logic standby_o,
  input logic lock_hit
);
  AST_OCP_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_det_i && !outs_off_o) |=> (outs_off_o && (flag_lo_o || standby_o))); // R1
  AST_PROT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i || ot_i || ov_i) |-> outs_off_o); // R4
  AST_PROT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((uv_i || ot_i || ov_i) && !standby_o) |-> flag_lo_o); // R4
  AST_LOCK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_n_i |=> !lock_hit); // R7
  AST_STBY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> (outs_off_o && flag_hi_o && !flag_lo_o)); // R9
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_hi_o && flag_lo_o)); // R9
endmodule

bind fault_lock_supervisor sup_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .uv_i      (uv_i),
  .ot_i      (ot_i),
  .ov_i      (ov_i),
  .oc_det_i  (oc_det_i),
  .en_n_i    (en_n_i),
  .outs_off_o(outs_off_o),
  .flag_lo_o (flag_lo_o),
  .flag_hi_o (flag_hi_o),
  .standby_o (standby_o),
  .lock_hit  (lock_hit)
);

// File: tb/tb_fault_lock_supervisor.sv
`timescale 1ns/1ps
module tb_fault_lock_supervisor;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic uv = 0, ot = 0, ov = 0, oc = 0, top = 0, bot = 0, lt = 0, hall = 0;
  logic dir = 0, brake_n = 1, en_n = 0;
  logic outs_off, flag_lo, flag_hi, standby;
  int total = 0, bad = 0;
  string phase = "R10";

  always #2 clk = ~clk;

  fault_lock_supervisor dut (
    .clk_i(clk), .rst_ni(rst_ni), .uv_i(uv), .ot_i(ot), .ov_i(ov),
    .oc_det_i(oc), .osc_top_i(top), .osc_bot_i(bot), .lock_tick_i(lt),
    .hall_step_i(hall), .dir_i(dir), .brake_n_i(brake_n), .en_n_i(en_n),
    .outs_off_o(outs_off), .flag_lo_o(flag_lo), .flag_hi_o(flag_hi),
    .standby_o(standby)
  );

  // reference model state
  int m_ocp = 0, m_ocnt = 0, m_lcnt = 0, m_dcnt = 0;
  bit m_locked = 0, m_dis = 1, p_dir = 0, p_en = 1, p_brake = 1;

  task automatic model_reset();
    m_ocp = 0; m_ocnt = 0; m_lcnt = 0; m_dcnt = 0;
    m_locked = 0; m_dis = 1; p_dir = 0; p_en = 1; p_brake = 1;
  endtask

  task automatic model_step();
    bit clr;
    case (m_ocp)
      0: if (oc) begin m_ocp = 1; m_ocnt = 0; end
      1: if (top) begin
           if (m_ocnt == 255) begin m_ocp = 2; m_ocnt = 0; end
           else m_ocnt++;
         end
      default: if (bot) m_ocp = 0;
    endcase
    clr = hall || (p_brake && !brake_n) || (!p_en && en_n) || (dir != p_dir) || en_n;
    if (clr) begin m_lcnt = 0; m_locked = 0; end
    else if (!en_n && brake_n && !m_locked && lt) begin
      if (m_lcnt == 255) begin m_locked = 1; m_lcnt = 0; end
      else m_lcnt++;
    end
    if (en_n) begin
      if (!m_dis && bot) begin
        if (m_dcnt == 3) begin m_dis = 1; m_dcnt = 0; end
        else m_dcnt++;
      end
    end else begin
      m_dcnt = 0;
      if (m_dis && bot) m_dis = 0;
    end
    p_dir = dir; p_en = en_n; p_brake = brake_n;
  endtask

  function automatic bit e_stby();
    return en_n && !brake_n;
  endfunction
  function automatic bit e_fault();
    return uv || ot || ov || (m_ocp == 1) || m_locked;
  endfunction
  function automatic bit e_off();
    return e_stby() || uv || ot || ov || (m_ocp != 0) || m_locked || m_dis;
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(outs_off, e_off(), {phase, " outs_off"});
    chk(flag_lo, !e_stby() && e_fault(), {phase, " flag_lo"});
    chk(flag_hi, e_stby(), {phase, " flag_hi"});
    chk(standby, e_stby(), {phase, " standby"});
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_ni) model_step();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic p_top(input int n);
    for (int i = 0; i < n; i++) begin top = 1; cyc(); top = 0; cyc(); end
  endtask
  task automatic p_bot(input int n);
    for (int i = 0; i < n; i++) begin bot = 1; cyc(); bot = 0; cyc(); end
  endtask
  task automatic p_lock(input int n);
    for (int i = 0; i < n; i++) begin lt = 1; cyc(); lt = 0; cyc(); end
  endtask

  initial begin
    #(4 * 190000);
    bad++;
    $display("FAIL watchdog: got running expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    phase = "R10";
    chk(outs_off, 1'b1, "R10 reset outs_off");
    chk(flag_lo, 1'b0, "R10 reset flag_lo");
    chk(flag_hi, 1'b0, "R10 reset flag_hi");
    cyc();
    p_bot(1);
    chk(outs_off, 1'b0, "R8 enable on first bottom");

    // overcurrent off-time with a disable cycle inside it
    phase = "R1";
    oc = 1; cyc(); oc = 0;
    chk(outs_off, 1'b1, "R1 outs off after detect");
    chk(flag_lo, 1'b1, "R1 flag low after detect");
    p_top(100);
    phase = "R3";
    oc = 1; cyc(); oc = 0;
    en_n = 1; cyc();
    p_bot(4);
    en_n = 0; cyc();
    p_bot(1);
    p_top(155);
    chk(flag_lo, 1'b1, "R3 flag still low at 255 tops");
    phase = "R2";
    p_top(1);
    chk(flag_lo, 1'b0, "R2 flag released at 256th top");
    chk(outs_off, 1'b1, "R2 outs held until bottom");
    p_bot(1);
    chk(outs_off, 1'b0, "R2 outs resume after bottom");

    // protection flags
    phase = "R4";
    uv = 1; cyc(); chk(flag_lo, 1'b1, "R4 uv flag"); uv = 0;
    ov = 1; cyc(); chk(outs_off, 1'b1, "R4 ov outs off"); ov = 0;
    ot = 1; cyc(); ot = 0; cyc();
    chk(flag_lo, 1'b0, "R4 flag floats when clear");

    // lock detect
    phase = "R5";
    hall = 1; cyc(); hall = 0;
    p_lock(255);
    chk(flag_lo, 1'b0, "R5 no lock at 255 ticks");
    p_lock(1);
    chk(flag_lo, 1'b1, "R5 lock flag at 256");
    chk(outs_off, 1'b1, "R5 lock outs off");
    phase = "R6";
    hall = 1; cyc(); hall = 0;
    chk(outs_off, 1'b0, "R6 hall clears lock");
    p_lock(100);
    uv = 1; p_lock(3); uv = 0;
    p_lock(152);
    chk(flag_lo, 1'b0, "R6 uv did not lock early");
    p_lock(1);
    chk(flag_lo, 1'b1, "R6 protection did not clear count");
    dir = ~dir; cyc();
    chk(flag_lo, 1'b0, "R6 dir change clears lock");
    p_lock(200);
    brake_n = 0; cyc();
    p_lock(300);
    chk(flag_lo, 1'b0, "R5 brake freezes count");
    brake_n = 1; cyc();
    p_lock(255);
    chk(flag_lo, 1'b0, "R6 brake fall cleared count");

    // narrow enable pulse: clears lock count, no disable
    phase = "R7";
    p_lock(1);
    chk(flag_lo, 1'b1, "R5 locked before pulse");
    en_n = 1; cyc(); p_bot(3);
    chk(flag_lo, 1'b0, "R7 lock held clear while en high");
    en_n = 0; cyc();
    phase = "R8";
    chk(outs_off, 1'b0, "R8 countdown abandoned");
    p_lock(255);
    chk(flag_lo, 1'b0, "R7 count restarted after pulse");
    en_n = 1; cyc(); p_bot(3);
    chk(outs_off, 1'b0, "R8 not disabled at 3 bottoms");
    p_bot(1);
    chk(outs_off, 1'b1, "R8 disabled at 4th bottom");

    phase = "R9";
    brake_n = 0; cyc();
    chk(flag_hi, 1'b1, "R9 standby flag high");
    chk(standby, 1'b1, "R9 standby indication");
    uv = 1; cyc(); chk(flag_lo, 1'b0, "R9 no pull low in standby"); uv = 0;
    brake_n = 1; en_n = 0; cyc(); p_bot(1);
    chk(outs_off, 1'b0, "R8 re-enable after standby");

    // seeded random mix
    phase = "R5 R6 R8 random";
    for (int k = 0; k < 60000; k++) begin
      uv = ($urandom % 400) == 0;
      ot = ($urandom % 600) == 0;
      ov = ($urandom % 600) == 0;
      oc = ($urandom % 900) == 0;
      top = ($urandom % 4) == 0;
      bot = ($urandom % 5) == 0;
      lt = ($urandom % 3) == 0;
      hall = ($urandom % 1500) == 0;
      if (($urandom % 2000) == 0) dir = ~dir;
      if (($urandom % 700) == 0) en_n = ~en_n;
      if (($urandom % 1200) == 0) brake_n = ~brake_n;
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule